// File: doc/BRIEF.md
# Rotating Phase-Spacing Histogram Detector

This block measures how far apart neighbouring sampling phases of a multi-phase time-interleaved front end really are, using code-density statistics. One shared pair of sampler outputs is connected, by an external selector that follows `pair_sel`, to channel k (lane 0) and channel k+1 (lane 1). The block holds each lane's return-to-zero result as a level, retimes both levels onto its own clock, and marks every clock on which the two levels disagree. That marks an input transition that fell between the two sampling instants. Over a fixed window the marks are counted, and the final count is the bin for that pair.

A sweep is started with a one-cycle `start`. The sequencer then walks the pair index through every channel, wrapping from the last channel back to the first. It discards a short settling interval after each switch, captures one bin per pair, and pulses `done` when the last bin is stored. Because the same two samplers see every pair, a constant sampler offset adds the same amount to every bin and cancels when the bins are compared. Stored bins are read back through a request/response port. A request is accepted on a clock where `req_valid` and `req_ready` are both high. `req_ready` is low only while a response is waiting and `rsp_ready` is low. A pending response keeps `rsp_valid` high and `rsp_data` unchanged until `rsp_ready` is seen high.

Top module: `phase_bin_hist`

## Requirements
- R1: After reset `busy`, `done` and `rsp_valid` are 0, `pair_sel` is 0, and every stored bin reads 0.
- R2: Each lane holds a level. A one-cycle pulse on `smp_set[i]` makes it 1 and a pulse on `smp_clr[i]` makes it 0. The level is kept while neither pulse is present, and set wins when both arrive together.
- R3: A clock counts as a hit when the retimed lane 0 and lane 1 levels differ. A hit adds to the window count four clocks after the pulse that caused it was sampled (latch, two retiming flops, compare register). Equal levels give no hits.
- R4: The window runs for 2^CNT_W-1 counted clocks. The stored bin equals the number of hits in those clocks, so lanes that always differ give a bin of 2^CNT_W-1.
- R5: On each pair switch both counters are cleared, and the next SETTLE clocks are not counted.
- R6: `busy` rises on the clock after `start` is seen while idle. It falls on the clock that `done` is high, and `done` is high for exactly one clock per sweep.
- R7: `start` has no effect while `busy` is high.
- R8: The response to an accepted request carries bin `req_idx` as stored before that clock. It appears on the next clock and is held with `rsp_data` stable while `rsp_ready` is low.
- R9: Bins keep their values after a sweep until the next sweep overwrites them.
- R10: `pair_sel` takes the values 0, 1, …, NUM_CH-1 in order within a sweep, never exceeds NUM_CH-1, and stays at NUM_CH-1 when the sweep ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common detector clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a sweep |
| smp_set | input | 2 | Per-lane pulse: sampler decided 1 |
| smp_clr | input | 2 | Per-lane pulse: sampler decided 0 |
| pair_sel | output | IDX_W | Current pair index k (lane 0 = channel k, lane 1 = channel k+1 mod NUM_CH) |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |
| req_valid | input | 1 | Bin read request valid |
| req_idx | input | IDX_W | Bin index to read |
| req_ready | output | 1 | Read request can be accepted |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_data | output | CNT_W | Bin value |

## Verification
The assertions check on every cycle that the hit count never exceeds the window count, that `pair_sel` stays in range and only steps upward by one during a sweep, that `done` marks the end of a busy period, that `start` while busy cannot restart the index, and that a stalled response holds. Only the bench's scenarios can show the bin values themselves. These are full-scale bins for permanently differing lanes, zero bins for matching lanes, and exact counts for a toggling pattern with skipped and colliding pulses, all compared against a behavioural model clock by clock. The same scenarios show that data arriving during the settling interval is excluded.

// File: rtl/phb_pkg.sv
package phb_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETTLE = 2'd1,
    SQ_COUNT  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/phb_front.sv
// Lane latches, retiming chains and the disagreement register.
module phb_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] set_p,
  input  logic [1:0] clr_p,
  output logic       hit
);
  logic [1:0] retimed;

  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    logic                   level_q;
    logic [SYNC_STAGES-1:0] chain_q;

    // R2: held level, set has priority
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             level_q <= 1'b0;
      else if (set_p[ln])     level_q <= 1'b1;
      else if (clr_p[ln])     level_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[SYNC_STAGES-2:0], level_q};
    end

    assign retimed[ln] = chain_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit <= 1'b0;
    else        hit <= retimed[0] ^ retimed[1];
  end
endmodule

// File: rtl/phb_window.sv
// Hit counter and window counter; the window freezes the hit count.
module phb_window #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             hit,
  output logic [CNT_W-1:0] hits,
  output logic [CNT_W-1:0] cycles,
  output logic             full
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  assign full = (cycles == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hits   <= '0;
      cycles <= '0;
    end else if (clr) begin
      hits   <= '0;
      cycles <= '0;
    end else if (run && !full) begin
      cycles <= cycles + 1'b1;
      hits   <= hits + CNT_W'(hit);
    end
  end
endmodule

// File: rtl/phb_seq.sv
// Pair sequencer: start, settle, count, store, advance.
module phb_seq #(
  parameter int NUM_CH = 8,
  parameter int SETTLE = 6,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SW    = $clog2(SETTLE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             full,
  output logic [IDX_W-1:0] pair,
  output logic             busy,
  output logic             done,
  output logic             clr,
  output logic             run,
  output logic             store
);
  import phb_pkg::*;

  localparam logic [IDX_W-1:0] LAST     = IDX_W'(NUM_CH - 1);
  localparam logic [SW-1:0]    SETTLE_E = SW'(SETTLE - 1);

  seq_state_t    state;
  logic [SW-1:0] settle_cnt;

  assign busy  = (state != SQ_IDLE);
  assign run   = (state == SQ_COUNT);
  assign store = run && full;
  assign clr   = ((state == SQ_IDLE) && start) || (store && (pair != LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SQ_IDLE;
      pair       <= '0;
      settle_cnt <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (start) begin
            pair       <= '0;
            settle_cnt <= '0;
            state      <= SQ_SETTLE;
          end
        end
        SQ_SETTLE: begin
          if (settle_cnt == SETTLE_E) state <= SQ_COUNT;
          else                        settle_cnt <= settle_cnt + 1'b1;
        end
        SQ_COUNT: begin
          if (full) begin
            if (pair == LAST) begin
              state <= SQ_IDLE;
              done  <= 1'b1;
            end else begin
              pair       <= pair + 1'b1;
              settle_cnt <= '0;
              state      <= SQ_SETTLE;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phb_bins.sv
// Bin storage with a valid/ready read port.
module phb_bins #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             store,
  input  logic [IDX_W-1:0] store_idx,
  input  logic [CNT_W-1:0] store_val,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_idx,
  output logic             req_ready,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [CNT_W-1:0] rsp_data
);
  logic [CNT_W-1:0] bin_q [NUM_CH];
  logic [CNT_W-1:0] rd_val;

  assign req_ready = !rsp_valid || rsp_ready;

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (req_idx == IDX_W'(i)) rd_val = bin_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) bin_q[i] <= '0;
    end else if (store) begin
      for (int i = 0; i < NUM_CH; i++)
        if (store_idx == IDX_W'(i)) bin_q[i] <= store_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (req_valid && req_ready) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/phase_bin_hist.sv
module phase_bin_hist #(
  parameter int NUM_CH      = 8,
  parameter int CNT_W       = 16,
  parameter int SETTLE      = 6,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       smp_set,
  input  logic [1:0]       smp_clr,
  output logic [IDX_W-1:0] pair_sel,
  output logic             busy,
  output logic             done,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_idx,
  output logic             req_ready,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [CNT_W-1:0] rsp_data
);
  logic             hit;
  logic [CNT_W-1:0] hit_cnt;
  logic [CNT_W-1:0] cyc_cnt;
  logic             win_full;
  logic             win_clr;
  logic             win_run;
  logic             bin_store;

  phb_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .set_p(smp_set), .clr_p(smp_clr), .hit(hit)
  );

  phb_window #(.CNT_W(CNT_W)) u_window (
    .clk(clk), .rst_n(rst_n), .clr(win_clr), .run(win_run), .hit(hit),
    .hits(hit_cnt), .cycles(cyc_cnt), .full(win_full)
  );

  phb_seq #(.NUM_CH(NUM_CH), .SETTLE(SETTLE)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .full(win_full),
    .pair(pair_sel), .busy(busy), .done(done),
    .clr(win_clr), .run(win_run), .store(bin_store)
  );

  phb_bins #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_bins (
    .clk(clk), .rst_n(rst_n), .store(bin_store), .store_idx(pair_sel),
    .store_val(hit_cnt), .req_valid(req_valid), .req_idx(req_idx),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data)
  );
endmodule

// File: rtl/phb_chk.sv
module phb_chk #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [IDX_W-1:0] pair_sel,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [CNT_W-1:0] rsp_data,
  input logic [CNT_W-1:0] hit_cnt,
  input logic [CNT_W-1:0] cyc_cnt
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CH - 1);

  // R4
  hits_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_cnt <= cyc_cnt);

  // R10
  pair_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_sel <= LAST);

  // R10
  pair_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (pair_sel != $past(pair_sel)))
      |-> (pair_sel == IDX_W'($past(pair_sel) + 1'b1)));

  // R6
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && (pair_sel != '0)) |=> (pair_sel != '0));

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

bind phase_bin_hist phb_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .pair_sel(pair_sel), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .hit_cnt(hit_cnt), .cyc_cnt(cyc_cnt)
);

// File: tb/phase_bin_hist_test.sv
`timescale 1ns/1ps
module phase_bin_hist_test;
  localparam int NC    = 8;
  localparam int CW    = 6;
  localparam int ST    = 6;
  localparam int IW    = 3;
  localparam int TOPV  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    smp_set = '0;
  logic [1:0]    smp_clr = '0;
  logic [IW-1:0] pair_sel;
  logic          busy, done, req_ready, rsp_valid;
  logic          req_valid = 1'b0;
  logic [IW-1:0] req_idx = '0;
  logic          rsp_ready = 1'b1;
  logic [CW-1:0] rsp_data;

  int checks = 0;
  int errors = 0;
  int mode = 0;
  int cyc = 0;
  int wd = 0;

  always #4 clk = ~clk;

  phase_bin_hist #(.NUM_CH(NC), .CNT_W(CW), .SETTLE(ST), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .smp_set(smp_set), .smp_clr(smp_clr),
    .pair_sel(pair_sel), .busy(busy), .done(done), .req_valid(req_valid),
    .req_idx(req_idx), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  // ---------------- behavioural reference ----------------
  int m_lat [2];
  int m_dl [4];
  int m_state, m_st, m_pair, m_a, m_b, m_done, m_rv, m_rd;
  int m_bins [NC];
  int m_x, m_rdy;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lat = '{0, 0}; m_dl = '{0, 0, 0, 0};
      m_state = 0; m_st = 0; m_pair = 0; m_a = 0; m_b = 0;
      m_done = 0; m_rv = 0; m_rd = 0;
      for (int i = 0; i < NC; i++) m_bins[i] = 0;
    end else begin
      m_rdy = (m_rv == 0 || rsp_ready) ? 1 : 0;
      if (req_valid && m_rdy == 1) begin m_rv = 1; m_rd = m_bins[req_idx]; end
      else if (rsp_ready) m_rv = 0;
      m_x = m_dl[3];
      m_dl[3] = m_dl[2]; m_dl[2] = m_dl[1]; m_dl[1] = m_dl[0];
      for (int l = 0; l < 2; l++) begin
        if (smp_set[l]) m_lat[l] = 1;
        else if (smp_clr[l]) m_lat[l] = 0;
      end
      m_dl[0] = m_lat[0] ^ m_lat[1];
      m_done = 0;
      if (m_state == 0) begin
        if (start) begin m_state = 1; m_st = 0; m_pair = 0; m_a = 0; m_b = 0; end
      end else if (m_state == 1) begin
        if (m_st == ST - 1) m_state = 2; else m_st++;
      end else begin
        if (m_b == TOPV) begin
          m_bins[m_pair] = m_a;
          if (m_pair == NC - 1) begin m_state = 0; m_done = 1; end
          else begin m_pair++; m_a = 0; m_b = 0; m_st = 0; m_state = 1; end
        end else begin
          m_b++; m_a += m_x;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 busy", busy, (m_state != 0) ? 1 : 0);
      chk("R6 done", done, m_done);
      chk("R10 pair_sel", pair_sel, m_pair);
      chk("R8 rsp_valid", rsp_valid, m_rv);
      chk("R8 req_ready", req_ready, (m_rv == 0 || rsp_ready) ? 1 : 0);
      if (m_rv == 1) chk("R4 rsp_data", rsp_data, m_rd);
    end
  end

  // sampler pulse generator
  always @(negedge clk) begin
    #1;
    cyc++;
    case (mode)
      1: begin smp_set = 2'b01; smp_clr = 2'b10; end           // lanes differ
      2: begin                                                    // toggling, lane 1 lags
        smp_set[0] = ((cyc % 14) < 7);
        smp_clr[0] = !smp_set[0];
        smp_set[1] = (((cyc + 12) % 14) < 7);
        smp_clr[1] = !smp_set[1];
        if (cyc % 11 == 0) begin smp_set[0] = 1'b1; smp_clr[0] = 1'b1; end
        if (cyc % 5 == 0) begin smp_set = '0; smp_clr = '0; end
      end
      3: begin smp_set = 2'b00; smp_clr = 2'b11; end           // both zero
      default: begin smp_set = '0; smp_clr = '0; end
    endcase
  end

  task automatic pulse_start();
    @(negedge clk); #2 start = 1'b1;
    @(negedge clk); #2 start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic read_chk(input int idx, input int exp, input string tag);
    @(negedge clk); #2 req_valid = 1'b1; req_idx = IW'(idx);
    @(negedge clk); #2 req_valid = 1'b0;
    chk(tag, rsp_data, exp);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 pair_sel", pair_sel, 0);
    read_chk(3, 0, "R1 bin");

    // R2 + R4: set lane 0 once, then no pulses: latch holds, bins full scale
    mode = 1; repeat (3) @(negedge clk);
    mode = 0; repeat (3) @(negedge clk);
    pulse_start();
    wait_done();
    for (int i = 0; i < NC; i++) read_chk(i, TOPV, "R2 R4 full-scale bin");

    // R3: equal levels give zero bins
    mode = 3; repeat (4) @(negedge clk);
    pulse_start();
    wait_done();
    for (int i = 0; i < NC; i++) read_chk(i, 0, "R3 zero bin");

    // R5 R7 toggling pattern with an extra start mid-sweep
    mode = 2;
    pulse_start();
    repeat (150) @(negedge clk);
    chk("R7 busy", busy, 1);
    pulse_start();
    chk("R7 pair not restarted", (pair_sel != 0) ? 1 : 0, 1);
    wait_done();
    for (int i = 0; i < NC; i++) read_chk(i, m_bins[i], "R5 pattern bin");

    // R8 back-pressure
    mode = 0;
    @(negedge clk); #2 rsp_ready = 1'b0; req_valid = 1'b1; req_idx = 3'd5;
    @(negedge clk); #2 req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 held valid", rsp_valid, 1);
    chk("R8 held data", rsp_data, m_bins[5]);
    #2 rsp_ready = 1'b1;
    @(negedge clk);

    // R9 bins persist
    repeat (20) @(negedge clk);
    read_chk(0, m_bins[0], "R9 retained");
    chk("R10 end index", pair_sel, NC - 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=0", wd);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule